// File: doc/BRIEF.md
# Timestamp Counter with One-Shot Compare Output

This block keeps a 64-bit nanosecond time counter for precision time synchronisation. It also has one compare channel that flips a general-purpose output when the counter reaches a programmed time. Software reaches the block through a flat 32-bit register port with five registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | action bits, a running status bit and the output source field |
| 1 | counter low | low 32 bits of the counter |
| 2 | counter high | high 32 bits of the counter |
| 3 | compare low | low 32 bits of the compare value |
| 4 | compare high | upper compare bits and the arm bit |

Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is high.

To set the time, software halts the counter and writes the two counter halves, in either order. It then resumes the counter. Every control write also rewrites the output source field, so software reads the control register first and writes back the source field together with the action bit it wants.

The compare channel is one-shot. Software writes the target time and sets the arm bit. When the counter steps onto that time, the routed output toggles and the hardware clears the arm bit. Nothing fires again until software re-arms the channel.

Top module: `ts_sync_timer`

## Requirements
- R1: After reset the counter reads 0, the counter is halted (control bit 2 reads 0), the source field reads 0, compare high reads 0 (disarmed) and `gpio_out` is 0.
- R2: While running, the counter grows by STEP_NS (default 1) at every edge, and wraps modulo 2^64. While halted, it holds its value.
- R3: Control register, address 0. Bit 0 is a halt action and bit 1 is a resume action; both read back as 0. Bit 2 reads 1 while the counter runs. Bits 5:4 are the source field, and every control write loads it from the written data. If bits 0 and 1 are both written as 1, halt wins. A control write with neither bit set leaves the run state unchanged. A resume takes effect from the edge after the write, and a halt stops the increment at the edge of the write itself.
- R4: A write to counter low (address 1) or counter high (address 2) replaces that half at the write edge. The other half keeps its value, and the counter does not increment at that edge.
- R5: A match occurs at an edge when the channel is armed, the counter is running and no counter or halt write occurs, and the incremented counter value equals the compare value. At that edge the counter takes the compare value and, with source field 01, `gpio_out` toggles.
- R6: Compare high (address 4) holds the upper compare bits 62:32 in its bits 30:0, and holds the arm bit at bit 31. Counter bit 63 takes no part in the comparison.
- R7: A match clears the arm bit, which reads back as 0. No further toggle follows without re-arming.
- R8: Writing 0 to compare high disarms the channel, so the target time then passes without a toggle.
- R9: With any source field value other than 01, `gpio_out` is 0. A match in that state still clears the arm bit but leaves the toggle state untouched, and that state reappears when the field is set back to 01.
- R10: When a compare-high write falls on the same edge as a match, the match still toggles the output and the arm bit takes the written value.
- R11: No match occurs while the counter is halted, or at an edge where a counter half is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1/2 counter low/high, 3/4 compare low/high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| gpio_out | output | 1 | Compare-driven output |

## Verification
A software write to the compare-high register can land on the very edge where the counter steps onto the target. The bench provokes this by loading the counter one step below the target and resuming. It then issues the re-arming write on the first counting edge. It expects the output to toggle at that edge and the arm bit to read back as the written 1.

The same kind of same-edge overlap is set up between a counter-half write and a would-be match. There the bench expects no toggle, and the arm bit must survive.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

  localparam int DW    = 32;
  localparam int CW    = 64;
  localparam int AW    = 3;
  localparam int SEL_W = 2;

  localparam logic [AW-1:0] A_CTRL   = 3'd0;
  localparam logic [AW-1:0] A_CNT_LO = 3'd1;
  localparam logic [AW-1:0] A_CNT_HI = 3'd2;
  localparam logic [AW-1:0] A_CMP_LO = 3'd3;
  localparam logic [AW-1:0] A_CMP_HI = 3'd4;

  localparam int CB_HALT   = 0;
  localparam int CB_RUN    = 1;
  localparam int CB_LIVE   = 2;
  localparam int CB_SEL_LO = 4;

  localparam int CMP_ARM_BIT = DW - 1;
  localparam int CMP_W       = CW - 1;

  localparam logic [SEL_W-1:0] SEL_OFF  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_CMP0 = 2'b01;

  function automatic logic [CW-1:0] ts_step(input logic [CW-1:0] v, input int unsigned s);
    return v + CW'(s);
  endfunction

  function automatic logic ts_equal(input logic [CW-1:0] nxt, input logic [CMP_W-1:0] target);
    return nxt[CMP_W-1:0] == target;
  endfunction

endpackage

// File: rtl/ts_ctrl_reg.sv
module ts_ctrl_reg
  import ts_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             halt_bit,
  input  logic             run_bit,
  input  logic [SEL_W-1:0] sel_in,
  output logic             running,
  output logic [SEL_W-1:0] sel,
  output logic             halt_now
);

  assign halt_now = ctrl_wr & halt_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      sel     <= SEL_OFF;
    end else if (ctrl_wr) begin
      sel <= sel_in;
      if (halt_bit)     running <= 1'b0;
      else if (run_bit) running <= 1'b1;
    end
  end

endmodule

// File: rtl/ts_counter.sv
module ts_counter
  import ts_sync_pkg::*;
#(
  parameter int unsigned STEP_NS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_next
);

  localparam int HI_W = CW - DW;

  assign cnt_next = ts_step(cnt_q, STEP_NS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[DW-1:0]  <= wdata;
      if (wr_hi) cnt_q[CW-1:DW] <= wdata[HI_W-1:0];
    end else if (advance) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/ts_compare.sv
module ts_compare
  import ts_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wdata,
  input  logic             advance,
  input  logic [CW-1:0]    cnt_next,
  input  logic             route,
  output logic [CMP_W-1:0] cmp_q,
  output logic             cmp_en,
  output logic             hit,
  output logic             tog_q
);

  localparam int UP_W = CMP_W - DW;

  assign hit = advance & cmp_en & ts_equal(cnt_next, cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      cmp_en <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      if (wr_lo) cmp_q[DW-1:0] <= wdata;
      if (wr_hi) begin
        cmp_q[CMP_W-1:DW] <= wdata[UP_W-1:0];
        cmp_en            <= wdata[CMP_ARM_BIT];
      end else if (hit) begin
        cmp_en <= 1'b0;
      end
      if (hit && route) tog_q <= ~tog_q;
    end
  end

endmodule

// File: rtl/ts_sync_timer.sv
module ts_sync_timer
  import ts_sync_pkg::*;
#(
  parameter int unsigned STEP_NS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          gpio_out
);

  localparam int UP_W = CMP_W - DW;

  logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi;
  logic             running, halt_now, advance, hit, cmp_en, tog_q, route;
  logic [SEL_W-1:0] sel;
  logic [CW-1:0]    cnt_q, cnt_next;
  logic [CMP_W-1:0] cmp_q;

  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt_lo = reg_wr && (reg_addr == A_CNT_LO);
  assign wr_cnt_hi = reg_wr && (reg_addr == A_CNT_HI);
  assign wr_cmp_lo = reg_wr && (reg_addr == A_CMP_LO);
  assign wr_cmp_hi = reg_wr && (reg_addr == A_CMP_HI);

  ts_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl),
    .halt_bit (reg_wdata[CB_HALT]),
    .run_bit  (reg_wdata[CB_RUN]),
    .sel_in   (reg_wdata[CB_SEL_LO +: SEL_W]),
    .running  (running),
    .sel      (sel),
    .halt_now (halt_now)
  );

  assign advance = running && !halt_now && !wr_cnt_lo && !wr_cnt_hi;
  assign route   = (sel == SEL_CMP0);

  ts_counter #(.STEP_NS(STEP_NS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .wr_lo    (wr_cnt_lo),
    .wr_hi    (wr_cnt_hi),
    .wdata    (reg_wdata),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  ts_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_cmp_lo),
    .wr_hi    (wr_cmp_hi),
    .wdata    (reg_wdata),
    .advance  (advance),
    .cnt_next (cnt_next),
    .route    (route),
    .cmp_q    (cmp_q),
    .cmp_en   (cmp_en),
    .hit      (hit),
    .tog_q    (tog_q)
  );

  assign gpio_out = route & tog_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CB_LIVE]             = running;
        reg_rdata[CB_SEL_LO +: SEL_W]  = sel;
      end
      A_CNT_LO: reg_rdata = cnt_q[DW-1:0];
      A_CNT_HI: reg_rdata = cnt_q[CW-1:DW];
      A_CMP_LO: reg_rdata = cmp_q[DW-1:0];
      A_CMP_HI: begin
        reg_rdata[CMP_ARM_BIT] = cmp_en;
        reg_rdata[UP_W-1:0]    = cmp_q[CMP_W-1:DW];
      end
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ts_sync_timer_chk.sv
module ts_sync_timer_chk
  import ts_sync_pkg::*;
#(
  parameter int unsigned STEP_NS = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [CW-1:0] cnt_q,
  input logic          advance,
  input logic          running,
  input logic          hit,
  input logic          cmp_en,
  input logic          route,
  input logic          gpio_out
);

  logic cnt_write, cmphi_write, ctrl_write;
  assign cnt_write   = reg_wr && (reg_addr == A_CNT_LO || reg_addr == A_CNT_HI);
  assign cmphi_write = reg_wr && (reg_addr == A_CMP_HI);
  assign ctrl_write  = reg_wr && (reg_addr == A_CTRL);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cnt_q == $past(cnt_q) + CW'(STEP_NS));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cnt_write) |=> $stable(cnt_q));

  p_armed_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cmp_en);

  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && route && !ctrl_write) |=> gpio_out != $past(gpio_out));

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmphi_write) |=> !cmp_en);

  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !route |-> !gpio_out);

  p_no_hit_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || cnt_write) |-> !hit);

endmodule

bind ts_sync_timer ts_sync_timer_chk #(.STEP_NS(STEP_NS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .cnt_q    (cnt_q),
  .advance  (advance),
  .running  (running),
  .hit      (hit),
  .cmp_en   (cmp_en),
  .route    (route),
  .gpio_out (gpio_out)
);

// File: tb/tb_ts_sync_timer.sv
module tb_ts_sync_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HALT = 32'h1;
  localparam logic [31:0] RUN  = 32'h2;
  localparam logic [31:0] S01  = 32'h10;
  localparam logic [31:0] S10  = 32'h20;
  localparam logic [31:0] ARM  = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        gpio_out;

  int checks = 0;
  int failures = 0;
  logic exp_g = 1'b0;
  logic done = 1'b0;

  ts_sync_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .gpio_out  (gpio_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_cnt(input logic [63:0] v);
    wr(3'd1, v[31:0]);
    wr(3'd2, v[63:32]);
  endtask

  task automatic arm(input logic [63:0] t);
    wr(3'd3, t[31:0]);
    wr(3'd4, ARM | {1'b0, t[62:32]});
  endtask

  task automatic shot(input logic [63:0] base, input int d);
    logic [63:0] tgt, v;
    logic [31:0] r;
    int bad_r5, bad_r7;
    tgt = base + 64'(d);
    bad_r5 = 0; bad_r7 = 0;
    wr(3'd0, HALT | S01);
    load_cnt(base);
    arm(tgt);
    wr(3'd0, RUN | S01);
    for (int k = 1; k <= d + 3; k++) begin
      @(negedge clk);
      if (k == d) exp_g = ~exp_g;
      if (gpio_out !== exp_g) begin
        if (k <= d) bad_r5++; else bad_r7++;
      end
    end
    chk(bad_r5 == 0, "R5/R6 toggle exactly at match edge", 64'(bad_r5), 0);
    chk(bad_r7 == 0, "R7 no second toggle", 64'(bad_r7), 0);
    rd(3'd4, r);
    chk(r[31] == 1'b0, "R7 arm bit cleared by match", 64'(r[31]), 0);
    rd64(v);
    chk(v == base + 64'(d + 3), "R2/R12 counter after sweep", v, base + 64'(d + 3));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, hi0;
    logic [63:0] v;
    logic [63:0] bases [4];
    bases[0] = 64'h0;
    bases[1] = 64'h0000_0000_FFFF_FFF0;
    bases[2] = 64'h8000_0001_FFFF_FFF8;
    bases[3] = 64'hFFFF_FFFF_FFFF_FFF5;

    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk(r == 32'h0, "R1 control after reset", 64'(r), 0);
    rd64(v);     chk(v == 64'h0, "R1 counter after reset", v, 0);
    rd(3'd4, r); chk(r == 32'h0, "R1 compare high after reset", 64'(r), 0);
    chk(gpio_out == 1'b0, "R1 output after reset", 64'(gpio_out), 0);
    wait_n(3);
    rd64(v);     chk(v == 64'h0, "R2 halted after reset holds", v, 0);

    // R3 control actions and readback
    wr(3'd0, RUN | S01);
    rd(3'd0, r); chk(r == 32'h14, "R3 running with source 01", 64'(r), 64'h14);
    wait_n(4);
    rd64(v);     chk(v == 64'd4, "R2 counts one per edge", v, 4);
    wr(3'd0, S10);
    rd(3'd0, r); chk(r == 32'h24, "R3 plain write keeps run state", 64'(r), 64'h24);
    rd64(v);     chk(v == 64'd5, "R3 plain write does not stop count", v, 5);
    wr(3'd0, HALT | RUN | S01);
    rd(3'd0, r); chk(r == 32'h10, "R3 halt wins over resume", 64'(r), 64'h10);
    rd64(v);     chk(v == 64'd5, "R3 halt stops at its own edge", v, 5);
    wait_n(3);
    rd64(v);     chk(v == 64'd5, "R2 holds while halted", v, 5);

    // R4 counter half writes
    wr(3'd1, 32'hDEAD_0000);
    rd64(v);     chk(v == 64'h0000_0000_DEAD_0000, "R4 low half write", v, 64'h0000_0000_DEAD_0000);
    wr(3'd2, 32'h0000_1234);
    rd64(v);     chk(v == 64'h0000_1234_DEAD_0000, "R4 high half write", v, 64'h0000_1234_DEAD_0000);
    wr(3'd0, RUN | S01);
    wait_n(2);
    rd(3'd2, hi0);
    wr(3'd1, 32'h10);
    rd64(v);     chk(v == {hi0, 32'h10}, "R4 write while running, no increment", v, {hi0, 32'h10});
    @(negedge clk);
    rd64(v);     chk(v == {hi0, 32'h11}, "R4 counting resumes after write", v, {hi0, 32'h11});

    // R5 R6 R7 R12 sweep over bases and distances
    for (int b = 0; b < 4; b++)
      for (int d = 1; d <= 12; d++)
        shot(bases[b], d);

    // R6 compare high readback masks bit 63 field
    wr(3'd0, HALT | S01);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, r); chk(r == 32'hFFFF_FFFF, "R6 compare high readback", 64'(r), 64'hFFFF_FFFF);
    wr(3'd4, 32'h0);

    // R9 unrouted match consumes arm, leaves latch
    wr(3'd0, HALT);
    load_cnt(64'd100);
    arm(64'd103);
    wr(3'd0, RUN);
    begin
      int bad = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (gpio_out !== 1'b0) bad++;
      end
      chk(bad == 0, "R9 output low when unrouted", 64'(bad), 0);
    end
    rd(3'd4, r); chk(r[31] == 1'b0, "R9 unrouted match clears arm", 64'(r[31]), 0);
    wr(3'd0, S01);
    chk(gpio_out == exp_g, "R9 latch unchanged on reroute", 64'(gpio_out), 64'(exp_g));

    // R8 disarm by zero write
    wr(3'd0, HALT | S01);
    load_cnt(64'd200);
    arm(64'd205);
    wr(3'd4, 32'h0);
    wr(3'd0, RUN | S01);
    wait_n(8);
    chk(gpio_out == exp_g, "R8 disarmed channel silent", 64'(gpio_out), 64'(exp_g));

    // R11 no match while halted or on counter write
    wr(3'd0, HALT | S01);
    arm(64'd300);
    load_cnt(64'd300);
    wait_n(3);
    chk(gpio_out == exp_g, "R11 no match while halted", 64'(gpio_out), 64'(exp_g));
    rd(3'd4, r); chk(r[31] == 1'b1, "R11 arm kept while halted", 64'(r[31]), 1);
    wr(3'd0, HALT | S01);
    load_cnt(64'd500);
    arm(64'd502);
    wr(3'd0, RUN | S01);
    @(negedge clk);
    wr(3'd1, 32'd700);
    wait_n(2);
    chk(gpio_out == exp_g, "R11 no match on counter write edge", 64'(gpio_out), 64'(exp_g));
    rd(3'd4, r); chk(r[31] == 1'b1, "R11 arm kept after blocked match", 64'(r[31]), 1);

    // R10 compare-high write on the match edge
    wr(3'd0, HALT | S01);
    load_cnt(64'd1000);
    arm(64'd1001);
    wr(3'd0, RUN | S01);
    wr(3'd4, ARM);
    exp_g = ~exp_g;
    chk(gpio_out == exp_g, "R10 match toggles despite write", 64'(gpio_out), 64'(exp_g));
    rd(3'd4, r); chk(r[31] == 1'b1, "R10 written arm bit wins", 64'(r[31]), 1);
    wr(3'd4, 32'h0);
    rd(3'd4, r); chk(r == 32'h0, "R8 zero write disarms", 64'(r), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule